// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Per-Pin Interrupt Detection

This block gives software control of 90 general-purpose pins, grouped as three banks of 30. A plain 32-bit register bus (address, write strobe, write data, combinational read data) reaches a 0x90-byte window. Each register function owns a 16-byte group, and inside a group the three banks sit one 32-bit word apart. Each pin has an output value, an output-enable derived from its direction bit, an ownership flag that tells the pin multiplexer the pin belongs to this controller, and a sampled input level that passes through a two-flop synchroniser.

Every pin can raise an interrupt. Each pin chooses level or edge detection and an active sense. A detected event sets a sticky status bit. Software clears that bit by writing a zero to its position. Each bank drives one level-sensitive interrupt line to the parent interrupt controller. The line is high while any pin in the bank has its status bit set, its mask bit open and its direction set to input. Edges are found by comparing synchronised samples, so software may rewrite the sense of an edge-mode pin after each event to catch both edges.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Register address = group base + 4 × bank, with bank 0..2. Group bases: 0x00 direction, 0x20 sense, 0x30 mode, 0x40 mask-open, 0x50 status, 0x60 ownership, 0x70 input level, 0x80 output value. A write lands only in the addressed bank's register.
- R2: Reads return zero and writes have no effect for these addresses: the group at 0x10, bank slot 3 of any group, any address with nonzero bits 1:0, and any address at or above 0x90.
- R3: Only bits 29:0 of each bank register exist. Bits 31:30 read as zero and ignore writes.
- R4: At reset, every direction bit is 1 (input). Sense, mode, mask-open, status, ownership and output value are 0, and no bank interrupt is raised.
- R5: For each pin, the output-enable is the inverse of its direction bit, the output pin carries the output-value bit, and the ownership output carries the ownership bit.
- R6: An input-level read returns each pin's level as sampled by the second synchroniser stage. A pin change is seen on the second rising edge after it, whatever the direction setting.
- R7: In level mode (mode bit 0), the status bit is set on every cycle the synchronised input equals the sense bit (1 = high, 0 = low). A clear written while that level holds does not take effect.
- R8: In edge mode (mode bit 1), the status bit is set when the synchronised input rises (sense 1) or falls (sense 0). The bit is set at the third rising edge after the pin change and stays set after the input returns.
- R9: Rewriting the sense bit of an edge-mode pin while its input is steady records no event. Software can therefore flip the sense after each event to catch both edges.
- R10: Writing 0 to a status bit clears it, unless an event occurs in the same cycle. Writing 1 leaves it unchanged.
- R11: A bank's interrupt is high exactly while some pin of that bank has status 1, mask-open 1 and direction 1. It falls once those are cleared, and it never pulses by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address inside the register window |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 90 | Pin levels, bank n in bits 30n+29..30n |
| pin_out | output | 90 | Output values |
| pin_oe | output | 90 | Output enables |
| pin_gpio_sel | output | 90 | Pin ownership flags to the pin multiplexer |
| bank_irq | output | 3 | Level interrupt per bank |

## Verification
The bench builds the block with its default parameters: three banks of 30 pins, 32-bit words and the 0x90-byte window. Because all three banks are present, it can check that bank slot 3 stays unmapped. Because the top two bits of every word are absent, it can check that they read as zero. It sweeps distinct patterns across every writable register of every bank, and probes each kind of unmapped address. Edge and level detection are driven on the lowest, a middle and the highest pin of each bank, and the cycle at which status and interrupts appear is checked against the synchroniser depth.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int GRP_CODE_W = 4;
  localparam int REG_W      = 32;

  // Register function codes (byte offset bits 7:4)
  localparam logic [GRP_CODE_W-1:0] GRP_DIR  = 4'h0;
  localparam logic [GRP_CODE_W-1:0] GRP_POL  = 4'h2;
  localparam logic [GRP_CODE_W-1:0] GRP_TYPE = 4'h3;
  localparam logic [GRP_CODE_W-1:0] GRP_EN   = 4'h4;
  localparam logic [GRP_CODE_W-1:0] GRP_STS  = 4'h5;
  localparam logic [GRP_CODE_W-1:0] GRP_OWN  = 4'h6;
  localparam logic [GRP_CODE_W-1:0] GRP_DIN  = 4'h7;
  localparam logic [GRP_CODE_W-1:0] GRP_DOUT = 4'h8;

  function automatic logic grp_is_mapped(input logic [GRP_CODE_W-1:0] g);
    return (g == GRP_DIR) || ((g >= GRP_POL) && (g <= GRP_DOUT));
  endfunction

  // Per-bit event detection: typ=1 edge, typ=0 level; pol=1 high/rising.
  function automatic logic [REG_W-1:0] detect_events(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] prev,
    input logic [REG_W-1:0] typ,
    input logic [REG_W-1:0] pol
  );
    logic [REG_W-1:0] rise, fall, lvl;
    rise = cur & ~prev;
    fall = ~cur & prev;
    lvl  = ~(cur ^ pol);
    return (typ & pol & rise) | (typ & ~pol & fall) | (~typ & lvl);
  endfunction

  // Sticky status: cleared bits drop, fresh events win.
  function automatic logic [REG_W-1:0] next_status(
    input logic [REG_W-1:0] old,
    input logic [REG_W-1:0] clr,
    input logic [REG_W-1:0] ev
  );
    return (old & ~clr) | ev;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 30,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NUM_BANKS    = 3,
  parameter int WINDOW_BYTES = 144,
  parameter int GROUP_BYTES  = 16,
  parameter int REG_BYTES    = 4,
  localparam int SLOT_LSB    = $clog2(REG_BYTES),
  localparam int GRP_LSB     = $clog2(GROUP_BYTES),
  localparam int SLOT_W      = GRP_LSB - SLOT_LSB
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic [GRP_CODE_W-1:0] grp,
  output logic [SLOT_W-1:0]     slot
);

  logic in_window, aligned, slot_ok;

  assign grp       = GRP_CODE_W'(addr[ADDR_W-1:GRP_LSB]);
  assign slot      = addr[GRP_LSB-1:SLOT_LSB];
  assign aligned   = (addr[SLOT_LSB-1:0] == '0);
  assign in_window = ({1'b0, addr} < (ADDR_W+1)'(WINDOW_BYTES));
  assign slot_ok   = ({1'b0, slot} < (SLOT_W+1)'(NUM_BANKS));
  assign hit       = in_window && aligned && slot_ok && grp_is_mapped(grp);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int PINS        = 30,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  we,
  input  logic [GRP_CODE_W-1:0] grp,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [PINS-1:0]       pin_in,
  output logic [PINS-1:0]       pin_out,
  output logic [PINS-1:0]       pin_oe,
  output logic [PINS-1:0]       pin_own,
  output logic                  irq
);

  localparam logic [DATA_W-1:0] PIN_MASK = {{(DATA_W-PINS){1'b0}}, {PINS{1'b1}}};

  logic [DATA_W-1:0] dir_q, pol_q, type_q, en_q, sts_q, own_q, dout_q;
  logic [PINS-1:0]   sync_pins, prev_q;
  logic [DATA_W-1:0] cur_w, prev_w, ev_vec, sts_clr, wmask;
  logic dir_wr, pol_wr, type_wr, en_wr, sts_wr, own_wr, dout_wr;

  // Write strobes per register function
  assign dir_wr  = sel && we && (grp == GRP_DIR);
  assign pol_wr  = sel && we && (grp == GRP_POL);
  assign type_wr = sel && we && (grp == GRP_TYPE);
  assign en_wr   = sel && we && (grp == GRP_EN);
  assign sts_wr  = sel && we && (grp == GRP_STS);
  assign own_wr  = sel && we && (grp == GRP_OWN);
  assign dout_wr = sel && we && (grp == GRP_DOUT);
  assign wmask   = wdata & PIN_MASK;

  // Input path: synchroniser then one history stage for edges
  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_pins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_pins;
  end

  assign cur_w   = {{(DATA_W-PINS){1'b0}}, sync_pins};
  assign prev_w  = {{(DATA_W-PINS){1'b0}}, prev_q};
  assign ev_vec  = detect_events(cur_w, prev_w, type_q, pol_q) & PIN_MASK;
  assign sts_clr = sts_wr ? (~wdata & PIN_MASK) : '0;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= PIN_MASK;
      pol_q  <= '0;
      type_q <= '0;
      en_q   <= '0;
      own_q  <= '0;
      dout_q <= '0;
    end else begin
      if (dir_wr)  dir_q  <= wmask;
      if (pol_wr)  pol_q  <= wmask;
      if (type_wr) type_q <= wmask;
      if (en_wr)   en_q   <= wmask;
      if (own_wr)  own_q  <= wmask;
      if (dout_wr) dout_q <= wmask;
    end
  end

  // Sticky status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= next_status(sts_q, sts_clr, ev_vec) & PIN_MASK;
  end

  assign irq     = |(sts_q & en_q & dir_q);
  assign pin_out = dout_q[PINS-1:0];
  assign pin_oe  = ~dir_q[PINS-1:0];
  assign pin_own = own_q[PINS-1:0];

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (grp)
        GRP_DIR:  rdata = dir_q;
        GRP_POL:  rdata = pol_q;
        GRP_TYPE: rdata = type_q;
        GRP_EN:   rdata = en_q;
        GRP_STS:  rdata = sts_q;
        GRP_OWN:  rdata = own_q;
        GRP_DIN:  rdata = cur_w;
        GRP_DOUT: rdata = dout_q;
        default:  rdata = '0;
      endcase
    end
  end

  // Any detected event is reflected in status one cycle later
  assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) |=> ((sts_q & $past(ev_vec)) == $past(ev_vec)));

  // A zero written to status removes the bit unless an event coincided
  assert_clear_applies_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((sts_q & ~$past(wdata) & ~$past(ev_vec)) == '0));

  // Status bits only appear through detected events
  assert_status_only_from_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(ev_vec)) == '0));

  // Edge-mode pins with a steady input produce no event, whatever the sense
  assert_no_edge_without_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((type_q & (cur_w ^ prev_w)) == '0) |-> ((ev_vec & type_q) == '0));

  // Output enables only move on a direction write
  assert_oe_follows_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_BANKS    = 3,
  parameter int PINS         = 30,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int WINDOW_BYTES = 144,
  parameter int GROUP_BYTES  = 16,
  parameter int SYNC_STAGES  = 2,
  localparam int TOTAL_PINS  = NUM_BANKS * PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [TOTAL_PINS-1:0] pin_in,
  output logic [TOTAL_PINS-1:0] pin_out,
  output logic [TOTAL_PINS-1:0] pin_oe,
  output logic [TOTAL_PINS-1:0] pin_gpio_sel,
  output logic [NUM_BANKS-1:0]  bank_irq
);

  localparam int REG_BYTES = DATA_W / 8;
  localparam int SLOT_W    = $clog2(GROUP_BYTES) - $clog2(REG_BYTES);

  logic                  dec_hit;
  logic [GRP_CODE_W-1:0] dec_grp;
  logic [SLOT_W-1:0]     dec_slot;
  logic [DATA_W-1:0]     bank_rdata [NUM_BANKS];

  gpio_addr_dec #(
    .ADDR_W       (ADDR_W),
    .NUM_BANKS    (NUM_BANKS),
    .WINDOW_BYTES (WINDOW_BYTES),
    .GROUP_BYTES  (GROUP_BYTES),
    .REG_BYTES    (REG_BYTES)
  ) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .grp  (dec_grp),
    .slot (dec_slot)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = dec_hit && (dec_slot == SLOT_W'(b));

    gpio_bank #(
      .PINS        (PINS),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (bank_sel),
      .we      (bus_we),
      .grp     (dec_grp),
      .wdata   (bus_wdata),
      .rdata   (bank_rdata[b]),
      .pin_in  (pin_in[b*PINS +: PINS]),
      .pin_out (pin_out[b*PINS +: PINS]),
      .pin_oe  (pin_oe[b*PINS +: PINS]),
      .pin_own (pin_gpio_sel[b*PINS +: PINS]),
      .irq     (bank_irq[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | bank_rdata[b];
  end

  // Decoder miss must leave the read mux quiet
  always_comb begin
    if (!dec_hit) begin
      assert_unmapped_reads_zero_R2: assert (bus_rdata == '0);
    end
  end

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;

  localparam int NB = 3;
  localparam int NP = 30;
  localparam logic [31:0] PMASK = 32'h3FFF_FFFF;
  localparam int G_DIR = 0, G_POL = 2, G_TYPE = 3, G_EN = 4, G_STS = 5,
                 G_OWN = 6, G_DIN = 7, G_DOUT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [89:0]   pin_in = '0;
  logic [89:0]   pin_out, pin_oe, pin_gpio_sel;
  logic [2:0]    bank_irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  gpio_bank_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .pin_gpio_sel (pin_gpio_sel),
    .bank_irq     (bank_irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] ra(int g, int b);
    return 8'(g * 16 + b * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_pins(int b, logic [29:0] v);
    pin_in[b*NP +: NP] = v;
  endtask

  logic [31:0] exp_reg [9][NB];

  initial begin
    int grps[5];
    grps = '{G_DIR, G_TYPE, G_EN, G_OWN, G_DOUT};

    // R4: reset state, read while reset is held
    cycles(2);
    for (int b = 0; b < NB; b++) begin
      chk_reg("R4 dir", ra(G_DIR, b), PMASK);
      chk_reg("R4 pol", ra(G_POL, b), 0);
      chk_reg("R4 type", ra(G_TYPE, b), 0);
      chk_reg("R4 en", ra(G_EN, b), 0);
      chk_reg("R4 sts", ra(G_STS, b), 0);
      chk_reg("R4 own", ra(G_OWN, b), 0);
      chk_reg("R4 dout", ra(G_DOUT, b), 0);
    end
    chk("R4 irq", {29'd0, bank_irq}, 0);
    chk("R4 oe", {2'b0, pin_oe[29:0]}, 0);
    @(negedge clk); rst_n = 1'b1;

    // Quiet state: active-high level on low pins, status cleared (R10)
    for (int b = 0; b < NB; b++) wr(ra(G_POL, b), 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) wr(ra(G_STS, b), 32'h0);
    for (int b = 0; b < NB; b++) chk_reg("R10 initial clear", ra(G_STS, b), 0);

    // R1/R3: distinct patterns to every writable register of every bank
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 5; i++) begin
        logic [31:0] p;
        p = 32'hC000_0000 | (32'h1357_9BDF ^ (grps[i] * 32'h0404_0404) ^ (b * 32'h2121_2121));
        exp_reg[grps[i]][b] = p & PMASK;
        wr(ra(grps[i], b), p);
      end
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 5; i++)
        chk_reg("R1 R3 readback", ra(grps[i], b), exp_reg[grps[i]][b]);
    // R5: pin outputs follow registers
    for (int b = 0; b < NB; b++) begin
      chk("R5 oe", {2'b0, pin_oe[b*NP +: NP]}, ~exp_reg[G_DIR][b] & PMASK);
      chk("R5 out", {2'b0, pin_out[b*NP +: NP]}, exp_reg[G_DOUT][b]);
      chk("R5 own", {2'b0, pin_gpio_sel[b*NP +: NP]}, exp_reg[G_OWN][b]);
    end
    // Sense register readback, then restore
    for (int b = 0; b < NB; b++) wr(ra(G_POL, b), 32'hFFF0_0F0F ^ (b << 8));
    for (int b = 0; b < NB; b++) chk_reg("R3 pol readback", ra(G_POL, b), (32'hFFF0_0F0F ^ (b << 8)) & PMASK);
    for (int b = 0; b < NB; b++) wr(ra(G_POL, b), 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) wr(ra(G_STS, b), 32'h0);

    // R2: unmapped addresses
    begin
      logic [7:0] holes[8];
      holes = '{8'h10, 8'h14, 8'h18, 8'h0C, 8'h01, 8'h90, 8'hFC, 8'h3C};
      for (int i = 0; i < 8; i++) begin
        wr(holes[i], 32'hFFFF_FFFF);
        chk_reg("R2 unmapped read", holes[i], 0);
      end
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < 5; i++)
          chk_reg("R2 no side effect", ra(grps[i], b), exp_reg[grps[i]][b]);
    end

    // Restore defaults
    for (int b = 0; b < NB; b++) begin
      wr(ra(G_DIR, b), PMASK); wr(ra(G_TYPE, b), 0); wr(ra(G_EN, b), 0);
      wr(ra(G_OWN, b), 0); wr(ra(G_DOUT, b), 0); wr(ra(G_STS, b), 0);
    end

    // R6: input level latency, independent of direction
    wr(ra(G_DIR, 1), 0);
    for (int b = 0; b < NB; b++) set_pins(b, 30'h2AAA_5555 ^ (b * 30'h0F0F_0F0F));
    cycles(1);
    for (int b = 0; b < NB; b++) chk_reg("R6 one edge", ra(G_DIN, b), 0);
    cycles(1);
    for (int b = 0; b < NB; b++) chk_reg("R6 two edges", ra(G_DIN, b), {2'b0, 30'h2AAA_5555 ^ (b * 30'h0F0F_0F0F)});
    wr(ra(G_DIR, 1), PMASK);
    pin_in = '0;
    cycles(3);
    for (int b = 0; b < NB; b++) wr(ra(G_STS, b), 0);

    // R8: edge detection on low, middle and high pins of every bank
    for (int b = 0; b < NB; b++)
      for (int j = 0; j < 3; j++) begin
        int k;
        logic [31:0] m;
        k = (j == 0) ? 0 : (j == 1) ? 13 : 29;
        m = 32'd1 << k;
        wr(ra(G_TYPE, b), m); wr(ra(G_EN, b), m);
        pin_in[b*NP + k] = 1'b1;
        cycles(2);
        chk_reg("R8 not yet", ra(G_STS, b), 0);
        chk("R11 not yet", {29'd0, bank_irq}, 0);
        cycles(1);
        chk_reg("R8 rise", ra(G_STS, b), m);
        chk("R11 irq", {29'd0, bank_irq}, 32'd1 << b);
        pin_in[b*NP + k] = 1'b0;
        cycles(3);
        chk_reg("R8 sticky", ra(G_STS, b), m);
        wr(ra(G_STS, b), ~m);
        chk_reg("R10 clear", ra(G_STS, b), 0);
        chk("R11 drop", {29'd0, bank_irq}, 0);
        wr(ra(G_POL, b), ~m);
        cycles(3);
        chk_reg("R9 sense rewrite", ra(G_STS, b), 0);
        pin_in[b*NP + k] = 1'b1;
        cycles(3);
        chk_reg("R8 rise ignored", ra(G_STS, b), 0);
        pin_in[b*NP + k] = 1'b0;
        cycles(3);
        chk_reg("R8 fall", ra(G_STS, b), m);
        wr(ra(G_STS, b), 0); wr(ra(G_POL, b), 32'hFFFF_FFFF);
        wr(ra(G_TYPE, b), 0); wr(ra(G_EN, b), 0);
      end

    // R9: both-edge emulation on bank 2 pin 5
    wr(ra(G_TYPE, 2), 32'h20);
    for (int i = 0; i < 4; i++) wr(ra(G_POL, 2), (i % 2) ? 32'hFFFF_FFFF : 32'hFFFF_FFDF);
    cycles(3);
    chk_reg("R9 toggled sense", ra(G_STS, 2), 0);
    pin_in[2*NP + 5] = 1'b1;
    cycles(3);
    chk_reg("R9 first edge", ra(G_STS, 2), 32'h20);
    wr(ra(G_STS, 2), 0); wr(ra(G_POL, 2), 32'hFFFF_FFDF);
    chk_reg("R9 after flip", ra(G_STS, 2), 0);
    pin_in[2*NP + 5] = 1'b0;
    cycles(3);
    chk_reg("R9 second edge", ra(G_STS, 2), 32'h20);
    wr(ra(G_STS, 2), 0); wr(ra(G_POL, 2), 32'hFFFF_FFFF); wr(ra(G_TYPE, 2), 0);

    // R7: level mode, clear overridden while level holds
    wr(ra(G_EN, 0), 32'h80);
    pin_in[7] = 1'b1;
    cycles(3);
    chk_reg("R7 high level", ra(G_STS, 0), 32'h80);
    wr(ra(G_STS, 0), 0);
    chk_reg("R7 clear overridden", ra(G_STS, 0), 32'h80);
    chk("R11 level irq", {29'd0, bank_irq}, 32'd1);
    pin_in[7] = 1'b0;
    cycles(3);
    wr(ra(G_STS, 0), 0);
    chk_reg("R7 clear after level", ra(G_STS, 0), 0);
    wr(ra(G_POL, 0), 32'hFFFF_FF7F);
    cycles(2);
    chk_reg("R7 low level", ra(G_STS, 0), 32'h80);
    pin_in[7] = 1'b1;
    cycles(3);
    wr(ra(G_STS, 0), 0);
    chk_reg("R7 low level gone", ra(G_STS, 0), 0);
    pin_in[7] = 1'b0;
    cycles(3);
    wr(ra(G_POL, 0), 32'hFFFF_FFFF); wr(ra(G_STS, 0), 0); wr(ra(G_EN, 0), 0);

    // R11: gating by mask and direction
    pin_in[1*NP + 3] = 1'b1;
    cycles(3);
    chk("R11 masked", {29'd0, bank_irq}, 0);
    wr(ra(G_DIR, 1), ~32'h8); wr(ra(G_EN, 1), 32'h8);
    chk("R11 output pin", {29'd0, bank_irq}, 0);
    wr(ra(G_DIR, 1), PMASK);
    chk("R11 input pin", {29'd0, bank_irq}, 32'd2);
    pin_in[1*NP + 3] = 1'b0;
    cycles(3);
    wr(ra(G_STS, 1), 0);
    chk("R11 released", {29'd0, bank_irq}, 0);
    wr(ra(G_EN, 1), 0);

    // R10: writing 1 keeps, writing 0 clears only that bit
    wr(ra(G_TYPE, 2), 32'h6);
    pin_in[2*NP + 1] = 1'b1; pin_in[2*NP + 2] = 1'b1;
    cycles(3);
    chk_reg("R10 two set", ra(G_STS, 2), 32'h6);
    wr(ra(G_STS, 2), 32'hFFFF_FFFF);
    chk_reg("R10 ones keep", ra(G_STS, 2), 32'h6);
    wr(ra(G_STS, 2), ~32'h2);
    chk_reg("R10 single clear", ra(G_STS, 2), 32'h4);
    wr(ra(G_STS, 2), ~32'h4);
    chk_reg("R10 second clear", ra(G_STS, 2), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule